// File: doc/BRIEF.md
# Wait-Extended Strobe Timer

This block sequences a single asynchronous memory access strobe through three timed phases: setup, an active-low pulse, and hold. The length of each phase is a programmed cycle count. During the pulse phase only, an active-low wait input can lengthen the access. How it does so depends on a 2-bit wait mode. In frozen mode, the pulse counter stops for every cycle in which wait is low, and the pulse then continues from the count where it stopped. In ready mode, the counter runs normally and wait is looked at only in the final pulse cycle. If wait is low there, the strobe stays low until wait rises.

The wait input is assumed to be already synchronized to the clock. The mode and the three cycle counts are captured in the cycle the start pulse is accepted. Later changes to them do not affect the access in flight. A one-cycle done pulse follows the final active cycle. A sticky error flag reports any access that asked for zero hold while wait handling was on. In that case one hold cycle is inserted anyway.

Top module: `strobe_wait_timer`

## Requirements
- R1: After reset, strobe_n is 1, phase is 0 (idle), done is 0 and cfg_err is 0.
- R2: A start seen while idle begins an access. With wait not stalling, the access lasts setup + max(pulse,1) + hold cycles of non-idle phase. A zero setup skips the setup phase. A zero hold skips the hold phase when wait handling is off.
- R3: The phase output encodes 0 idle, 1 setup, 2 pulse, 3 hold. strobe_n is 0 exactly in the cycles where phase is 2, including cycles added by wait.
- R4: done is high for exactly one cycle, in the cycle right after the last non-idle cycle, and phase is 0 in that cycle.
- R5: Mode 0 (off) and mode 1 (reserved) ignore wait_n completely, so the access length is unchanged whatever wait_n does.
- R6: wait_n has no effect while phase is setup or hold, in any mode.
- R7: In mode 2 (frozen), each pulse cycle that sees wait_n low adds exactly one cycle to the pulse phase, and counting resumes where it stopped.
- R8: In mode 3 (ready), wait_n is examined only in the last programmed pulse cycle. If it is low there, the pulse is extended until the first cycle in which wait_n is high, which is the final pulse cycle. A low wait_n earlier in the pulse adds nothing.
- R9: When the mode is 2 or 3 and the programmed hold is 0, one hold cycle is inserted and cfg_err is set. cfg_err then stays 1 until reset.
- R10: A start while an access is in progress is ignored. Changes to mode or the cycle counts after an access has started do not alter that access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an access (accepted only when idle) |
| wait_mode | input | 2 | 0 off, 1 reserved (off), 2 frozen, 3 ready |
| setup_cyc | input | CW | Setup phase length in cycles |
| pulse_cyc | input | CW | Pulse phase length in cycles (0 treated as 1) |
| hold_cyc | input | CW | Hold phase length in cycles |
| wait_n | input | 1 | Synchronized active-low wait from the device |
| strobe_n | output | 1 | Active-low control strobe |
| phase | output | 2 | Current phase: 0 idle, 1 setup, 2 pulse, 3 hold |
| done | output | 1 | One-cycle pulse after the access ends |
| cfg_err | output | 1 | Sticky flag: zero hold requested with wait enabled |

## Verification
The bench lays wait-low windows across the setup phase, the hold phase, the start of the pulse, and exactly the last pulse cycle. A design that let wait leak outside the pulse, or that let ready mode stall early, would therefore return a longer access than the scoreboard predicts. Frozen windows in the middle of the pulse catch a counter that restarts or skips a count, since either one changes the total by the wait length. Zero setup, pulse and hold values, and a hold of zero with wait enabled, show up any phase that is not skipped, not forced, or not flagged. A second start and altered inputs during a long access would show up as an extra done or a changed length in a design that re-captures its configuration.

// File: rtl/swt_pkg.sv
package swt_pkg;

  typedef enum logic [1:0] {
    WM_OFF    = 2'd0,
    WM_RSVD   = 2'd1,
    WM_FROZEN = 2'd2,
    WM_READY  = 2'd3
  } wait_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_PULSE = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

  function automatic logic wait_enabled(input wait_mode_e m);
    return (m == WM_FROZEN) || (m == WM_READY);
  endfunction

endpackage

// File: rtl/swt_cfg.sv
module swt_cfg
  import swt_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          busy,
  input  logic [1:0]    mode_i,
  input  logic [CW-1:0] setup_i,
  input  logic [CW-1:0] pulse_i,
  input  logic [CW-1:0] hold_i,
  output wait_mode_e    mode_o,
  output logic [CW-1:0] setup_o,
  output logic [CW-1:0] pulse_o,
  output logic [CW-1:0] hold_o,
  output logic          cfg_err
);

  localparam logic [CW-1:0] ONE = CW'(1);

  function automatic logic [CW-1:0] pulse_eff(input logic [CW-1:0] p);
    return (p == '0) ? ONE : p;
  endfunction

  function automatic logic hold_forced(input wait_mode_e m, input logic [CW-1:0] h);
    return wait_enabled(m) && (h == '0);
  endfunction

  function automatic logic [CW-1:0] hold_eff(input wait_mode_e m, input logic [CW-1:0] h);
    return hold_forced(m, h) ? ONE : h;
  endfunction

  wait_mode_e    mode_c, mode_q;
  logic [CW-1:0] pulse_c, hold_c;
  logic [CW-1:0] setup_q, pulse_q, hold_q;
  logic          err_q;

  assign mode_c  = wait_mode_e'(mode_i);
  assign pulse_c = pulse_eff(pulse_i);
  assign hold_c  = hold_eff(mode_c, hold_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= WM_OFF;
      setup_q <= '0;
      pulse_q <= ONE;
      hold_q  <= '0;
      err_q   <= 1'b0;
    end else if (take) begin
      mode_q  <= mode_c;
      setup_q <= setup_i;
      pulse_q <= pulse_c;
      hold_q  <= hold_c;
      if (hold_forced(mode_c, hold_i)) err_q <= 1'b1;
    end
  end

  assign mode_o  = busy ? mode_q  : mode_c;
  assign setup_o = busy ? setup_q : setup_i;
  assign pulse_o = busy ? pulse_q : pulse_c;
  assign hold_o  = busy ? hold_q  : hold_c;
  assign cfg_err = err_q;

endmodule

// File: rtl/swt_wait_gate.sv
module swt_wait_gate
  import swt_pkg::*;
(
  input  wait_mode_e mode,
  input  logic       in_pulse,
  input  logic       last_cnt,
  input  logic       wait_n,
  output logic       stall
);

  logic frozen_hit, ready_hit;

  assign frozen_hit = (mode == WM_FROZEN);
  assign ready_hit  = (mode == WM_READY) && last_cnt;
  assign stall      = in_pulse && !wait_n && (frozen_hit || ready_hit);

endmodule

// File: rtl/swt_seq.sv
module swt_seq
  import swt_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] setup_len,
  input  logic [CW-1:0] pulse_len,
  input  logic [CW-1:0] hold_len,
  input  logic          stall,
  output phase_e        phase,
  output logic [CW-1:0] cnt,
  output logic          last,
  output logic          accept,
  output logic          busy,
  output logic          done
);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  assign last   = (cnt_q == CW'(1));
  assign busy   = (ph_q != PH_IDLE);
  assign accept = start && !busy;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          if (setup_len != '0) begin
            ph_d  = PH_SETUP;
            cnt_d = setup_len;
          end else begin
            ph_d  = PH_PULSE;
            cnt_d = pulse_len;
          end
        end
      end
      PH_SETUP: begin
        if (last) begin
          ph_d  = PH_PULSE;
          cnt_d = pulse_len;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_PULSE: begin
        if (!stall) begin
          if (!last) begin
            cnt_d = cnt_q - 1'b1;
          end else if (hold_len != '0) begin
            ph_d  = PH_HOLD;
            cnt_d = hold_len;
          end else begin
            ph_d   = PH_IDLE;
            cnt_d  = '0;
            done_d = 1'b1;
          end
        end
      end
      PH_HOLD: begin
        if (last) begin
          ph_d   = PH_IDLE;
          cnt_d  = '0;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign phase = ph_q;
  assign cnt   = cnt_q;
  assign done  = done_q;

endmodule

// File: rtl/strobe_wait_timer.sv
module strobe_wait_timer
  import swt_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    wait_mode,
  input  logic [CW-1:0] setup_cyc,
  input  logic [CW-1:0] pulse_cyc,
  input  logic [CW-1:0] hold_cyc,
  input  logic          wait_n,
  output logic          strobe_n,
  output logic [1:0]    phase,
  output logic          done,
  output logic          cfg_err
);

  wait_mode_e    mode_w;
  phase_e        phase_w;
  logic [CW-1:0] setup_w, pulse_w, hold_w, cnt_w;
  logic          last_w, accept_w, busy_w, stall_w;

  swt_cfg #(.CW(CW)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (accept_w),
    .busy    (busy_w),
    .mode_i  (wait_mode),
    .setup_i (setup_cyc),
    .pulse_i (pulse_cyc),
    .hold_i  (hold_cyc),
    .mode_o  (mode_w),
    .setup_o (setup_w),
    .pulse_o (pulse_w),
    .hold_o  (hold_w),
    .cfg_err (cfg_err)
  );

  swt_wait_gate u_gate (
    .mode     (mode_w),
    .in_pulse (phase_w == PH_PULSE),
    .last_cnt (last_w),
    .wait_n   (wait_n),
    .stall    (stall_w)
  );

  swt_seq #(.CW(CW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .setup_len (setup_w),
    .pulse_len (pulse_w),
    .hold_len  (hold_w),
    .stall     (stall_w),
    .phase     (phase_w),
    .cnt       (cnt_w),
    .last      (last_w),
    .accept    (accept_w),
    .busy      (busy_w),
    .done      (done)
  );

  assign phase    = phase_w;
  assign strobe_n = (phase_w != PH_PULSE);

endmodule

// File: rtl/swt_chk.sv
module swt_chk
  import swt_pkg::*;
#(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strobe_n,
  input logic [1:0]    phase,
  input logic          done,
  input logic          cfg_err,
  input logic          stall,
  input logic          last,
  input logic [CW-1:0] cnt,
  input wait_mode_e    mode
);

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (phase == PH_IDLE));

  // R3
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |-> (phase == PH_PULSE));

  // R5
  wait_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WM_OFF || mode == WM_RSVD) |-> !stall);

  // R6
  stall_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (phase == PH_PULSE));

  // R7
  frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (phase == PH_PULSE) && $stable(cnt));

  // R8
  ready_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WM_READY && !last) |-> !stall);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R9
  hold_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PULSE && wait_enabled(mode) && last && !stall) |=> (phase == PH_HOLD));

endmodule

bind strobe_wait_timer swt_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .strobe_n (strobe_n),
  .phase    (phase),
  .done     (done),
  .cfg_err  (cfg_err),
  .stall    (stall_w),
  .last     (last_w),
  .cnt      (cnt_w),
  .mode     (mode_w)
);

// File: tb/sim_strobe_wait_timer.sv
`timescale 1ns/1ps
module sim_strobe_wait_timer;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    wait_mode = 2'd0;
  logic [CW-1:0] setup_cyc = '0, pulse_cyc = '0, hold_cyc = '0;
  logic          wait_n = 1'b1;
  logic          strobe_n, done, cfg_err;
  logic [1:0]    phase;

  strobe_wait_timer #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wait_mode(wait_mode),
    .setup_cyc(setup_cyc), .pulse_cyc(pulse_cyc), .hold_cyc(hold_cyc),
    .wait_n(wait_n), .strobe_n(strobe_n), .phase(phase), .done(done),
    .cfg_err(cfg_err)
  );

  always #2.5 clk = ~clk;

  int    n_chk = 0, n_fail = 0;
  int    exp_q[$];
  string tag_q[$];
  int    active_len = 0, pidx = 0, cyc = 0;
  int    win_lo = 0, win_len = 0;
  bit    win_setup = 0, win_hold = 0, exp_err = 0, finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: scoreboard pop, strobe check, wait_n stimulus by phase
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        check(phase == 2'd0, "R4", "phase during done", phase, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected done", 1, 0);
        end else begin
          check(active_len == exp_q[0], tag_q[0], "access length", active_len, exp_q[0]);
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
        active_len = 0;
      end
      if (phase != 2'd0) begin
        active_len++;
        check(strobe_n == (phase != 2'd2), "R3", "strobe level", strobe_n, phase != 2'd2);
      end
      if (phase == 2'd2) begin
        wait_n = !(pidx >= win_lo && pidx < win_lo + win_len);
        pidx++;
      end else begin
        pidx = 0;
        if (phase == 2'd1) wait_n = !win_setup;
        else if (phase == 2'd3) wait_n = !win_hold;
        else wait_n = 1'b1;
      end
    end
  end

  task automatic access(input int m, input int s, input int p, input int h,
                        input int lo, input int len, input bit ws, input bit wh,
                        input bit again, input string tag);
    int pe, he, st;
    pe = (p == 0) ? 1 : p;
    he = (m >= 2 && h == 0) ? 1 : h;
    st = 0;
    if (m == 2 && len > 0 && lo <= pe - 1) st = len;
    if (m == 3 && lo <= pe - 1 && lo + len > pe - 1) st = lo + len - (pe - 1);
    if (m >= 2 && h == 0) exp_err = 1;
    exp_q.push_back(s + pe + he + st);
    tag_q.push_back(tag);
    @(negedge clk);
    win_lo = lo; win_len = len; win_setup = ws; win_hold = wh;
    wait_mode = 2'(m); setup_cyc = CW'(s); pulse_cyc = CW'(p); hold_cyc = CW'(h);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_mode = 2'd3; setup_cyc = '1; pulse_cyc = '1; hold_cyc = '0;
    if (again) begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    check(cfg_err == exp_err, "R9", "cfg_err", cfg_err, exp_err);
    @(negedge clk);
    @(negedge clk);
    check(phase == 2'd0, "R10", "idle after access", phase, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(strobe_n == 1'b1, "R1", "strobe_n", strobe_n, 1);
    check(phase == 2'd0, "R1", "phase", phase, 0);
    check(done == 1'b0, "R1", "done", done, 0);
    check(cfg_err == 1'b0, "R1", "cfg_err", cfg_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    access(0, 2, 3, 2, 0, 0, 0, 0, 0, "R2");        // plain: 7
    access(0, 2, 3, 2, 0, 4, 1, 1, 0, "R5");        // wait ignored when off
    access(1, 2, 3, 2, 0, 4, 1, 1, 0, "R5");        // reserved acts as off
    access(2, 1, 4, 1, 1, 3, 0, 0, 0, "R7");        // frozen mid-pulse: 9
    access(2, 3, 2, 1, 0, 0, 1, 1, 0, "R6");        // wait only in setup/hold
    access(3, 1, 4, 1, 0, 2, 0, 0, 0, "R8");        // ready early low: 6
    access(3, 1, 4, 1, 2, 5, 0, 0, 0, "R8");        // ready extended: 10
    access(3, 2, 1, 1, 0, 1, 0, 0, 0, "R8");        // last-cycle-only: 5
    access(2, 0, 5, 2, 0, 1, 0, 0, 0, "R7");        // frozen at pulse start: 8
    access(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");        // all zero: 1
    access(0, 3, 4, 3, 0, 0, 0, 0, 1, "R10");       // second start ignored: 10
    access(2, 0, 2, 0, 0, 0, 0, 0, 0, "R9");        // forced hold: 3
    access(0, 1, 1, 0, 0, 0, 0, 0, 0, "R9");        // err stays set: 2
    check(exp_q.size() == 0, "R4", "missing done pulses", exp_q.size(), 0);
    finished = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog expired: got %0d cycles expected under 20000", cyc);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule